// File: doc/BRIEF.md
# Configurable Interrupt Trigger Detector

This block turns a bank of external interrupt request lines into a vector of raw pending bits. Each source has its own trigger mode, picked by three per-source configuration vectors. A source can respond to a high level, a low level, a rising edge, a falling edge or either edge. Every request line first passes through a two-stage synchronizer. After that, the block compares the synchronized sample with a stored copy of that source's previous sample.

In level mode the raw bit follows the synchronized input, inverted when the source is active-low. In edge mode a qualifying transition sets the raw bit, and the bit stays set until the register block sends a one-cycle clear pulse for that source. The raw vector goes to downstream masking and routing logic, which are not part of this block.

Top module: `irq_trigger_detector`

## Requirements
- R1: A source with `cfg_level`=1 and `cfg_polarity`=1 is active-high: its `raw_status` bit equals its synchronized input level.
- R2: A source with `cfg_level`=1 and `cfg_polarity`=0 is active-low: its `raw_status` bit equals the inverse of its synchronized input level.
- R3: A source with `cfg_level`=0 and `cfg_any_edge`=1 sets its `raw_status` bit on any change of its synchronized input, in either direction.
- R4: A source with `cfg_level`=0 and `cfg_any_edge`=0 sets its `raw_status` bit on a low-to-high transition when `cfg_polarity`=1, and on a high-to-low transition when `cfg_polarity`=0. A transition in the other direction has no effect.
- R5: In edge mode a set `raw_status` bit holds until `edge_clr` is 1 for that source. With no qualifying edge, the bit stays 0.
- R6: The stored previous level of every source is updated on every clock, whatever the mode. After a source switches from level mode to edge mode, only a transition that happens after the switch can set its bit.
- R7: A change on `irq_in` reaches `raw_status` on the third rising clock edge after the change. Two of these edges are taken by the synchronizer.
- R8: If `edge_clr` and a qualifying edge occur in the same cycle for one source, the edge wins and the bit remains set.
- R9: While `rst_n` is 0, `raw_status`, the synchronizer and the previous-level record are all 0.
- R10: `edge_clr` has no effect on a source in level mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Interrupt request levels; may be asynchronous to clk |
| cfg_level | input | NUM_SRC | 1 selects level mode, 0 selects edge mode |
| cfg_polarity | input | NUM_SRC | 1 selects active-high or rising; 0 selects active-low or falling |
| cfg_any_edge | input | NUM_SRC | 1 selects detection of both edges when in edge mode |
| edge_clr | input | NUM_SRC | One-cycle clear pulse per source for latched edge bits |
| raw_status | output | NUM_SRC | Raw pending vector |

## Verification
The per-source assertions relate the configuration and clear inputs seen in one cycle to the raw bit in the next cycle. They therefore assume that `cfg_level`, `cfg_polarity`, `cfg_any_edge` and `edge_clr` are synchronous to `clk`. Only `irq_in` is assumed to be asynchronous. The bench meets this by driving every input on the falling edge. Configuration changes are rare and random, request lines flip sparsely, and clear pulses land at random points, including on the cycle that an edge is detected.

// File: rtl/irq_trig_pkg.sv
`timescale 1ns/1ps
package irq_trig_pkg;

  // Edge qualification for one source, from its current and previous samples.
  function automatic logic edge_seen(input logic pol, input logic any,
                                     input logic cur, input logic prev);
    logic hit;
    if (any)      hit = cur ^ prev;
    else if (pol) hit = cur & ~prev;
    else          hit = ~cur & prev;
    return hit;
  endfunction

  // Next value of one raw bit.
  function automatic logic raw_next(input logic lvl, input logic pol,
                                    input logic any, input logic cur,
                                    input logic prev, input logic raw,
                                    input logic clr);
    logic nxt;
    if (lvl) nxt = pol ? cur : ~cur;
    else     nxt = (raw & ~clr) | edge_seen(pol, any, cur, prev);
    return nxt;
  endfunction

endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
  parameter int WIDTH  = 51,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign d_out = stage_q[LAST];
endmodule

// File: rtl/irq_trig_cell.sv
`timescale 1ns/1ps
module irq_trig_cell
  import irq_trig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_level,
  input  logic cfg_pol,
  input  logic cfg_any,
  input  logic cur,
  input  logic clr,
  output logic raw
);
  logic prev_q;
  logic raw_q;
  logic edge_hit;

  // Named event: a qualifying edge while in edge mode.
  assign edge_hit = ~cfg_level & edge_seen(cfg_pol, cfg_any, cur, prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      prev_q <= cur;
      raw_q  <= raw_next(cfg_level, cfg_pol, cfg_any, cur, prev_q, raw_q, clr);
    end
  end

  assign raw = raw_q;

  // R1
  lvl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_level && cfg_pol) |=> (raw_q == $past(cur)));

  // R2
  lvl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_level && !cfg_pol) |=> (raw_q == !$past(cur)));

  // R8
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && clr) |=> raw_q);

  // R5
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_level && raw_q && !clr) |=> raw_q);

  // R5
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_level && !raw_q && !edge_hit) |=> !raw_q);
endmodule

// File: rtl/irq_trigger_detector.sv
`timescale 1ns/1ps
module irq_trigger_detector #(
  parameter int NUM_SRC     = 51,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] cfg_level,
  input  logic [NUM_SRC-1:0] cfg_polarity,
  input  logic [NUM_SRC-1:0] cfg_any_edge,
  input  logic [NUM_SRC-1:0] edge_clr,
  output logic [NUM_SRC-1:0] raw_status
);
  logic [NUM_SRC-1:0] irq_synced;

  irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (irq_in),
    .d_out (irq_synced)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irq_trig_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_level (cfg_level[i]),
      .cfg_pol   (cfg_polarity[i]),
      .cfg_any   (cfg_any_edge[i]),
      .cur       (irq_synced[i]),
      .clr       (edge_clr[i]),
      .raw       (raw_status[i])
    );
  end

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (raw_status == '0) || rst_n);
endmodule

// File: tb/test_irq_trigger_detector.sv
`timescale 1ns/1ps
module test_irq_trigger_detector;
  localparam int N = 51;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n;
  logic [N-1:0] irq, lvl, pol, any, clr, raw;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  irq_trigger_detector #(.NUM_SRC(N), .SYNC_STAGES(2)) i_irq_trigger_detector (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .cfg_level(lvl),
    .cfg_polarity(pol), .cfg_any_edge(any), .edge_clr(clr), .raw_status(raw)
  );

  // Reference model, written in vector form from the requirements.
  logic [N-1:0] m_s1, m_s2, m_prev, m_raw;

  function automatic logic [N-1:0] model_next(
    input logic [N-1:0] l, p, a, c, pv, r, cl);
    logic [N-1:0] edges;
    edges = (a & (c ^ pv)) | (~a & p & c & ~pv) | (~a & ~p & ~c & pv);
    return (l & ~(c ^ p)) | (~l & ((r & ~cl) | edges));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_raw = '0;
    end else begin
      m_raw  = model_next(lvl, pol, any, m_s2, m_prev, m_raw, clr);
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = irq;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_bit(input int idx, input logic exp, input string tag);
    checks++;
    if (raw[idx] !== exp) begin
      errors++;
      $display("FAIL %s bit %0d actual %b expected %b", tag, idx, raw[idx], exp);
    end
  endtask

  task automatic check_vec(input string tag);
    checks++;
    if (raw !== m_raw) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, raw, m_raw);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    irq   = '0;
    clr   = '0;
    lvl   = {N{1'b1}};
    pol   = {N{1'b1}};
    any   = '0;
    lvl[4:2] = 3'b000;
    pol[1] = 1'b0;
    pol[3] = 1'b0;
    any[4] = 1'b1;
    tick(3);
    check_vec("R9 raw zero in reset");
    check_bit(1, 1'b0, "R9");
    rst_n = 1'b1;
    tick(3);
    check_bit(0, 1'b0, "R1 idle");
    check_bit(1, 1'b1, "R2 idle low input");
    check_bit(2, 1'b0, "R4 idle");

    irq[4:0] = 5'b11111;
    tick(2);
    check_bit(0, 1'b0, "R7 not yet after two edges");
    tick(1);
    check_bit(0, 1'b1, "R7 R1 after third edge");
    check_bit(1, 1'b0, "R2");
    check_bit(2, 1'b1, "R4 rising");
    check_bit(3, 1'b0, "R4 falling ignores rise");
    check_bit(4, 1'b1, "R3 rise");

    clr[0] = 1'b1; clr[2] = 1'b1; clr[4] = 1'b1;
    tick(1);
    clr = '0;
    check_bit(2, 1'b0, "R5 cleared");
    check_bit(4, 1'b0, "R5 cleared");
    check_bit(0, 1'b1, "R10 level ignores clear");
    tick(3);
    check_bit(2, 1'b0, "R5 no new edge");

    irq[4:0] = 5'b00000;
    tick(3);
    check_bit(3, 1'b1, "R4 falling");
    check_bit(4, 1'b1, "R3 fall");
    check_bit(2, 1'b0, "R4 rising ignores fall");
    check_bit(1, 1'b1, "R2");
    tick(5);
    check_bit(3, 1'b1, "R5 latched");

    irq[2] = 1'b1;
    tick(2);
    clr[2] = 1'b1;
    tick(1);
    clr = '0;
    check_bit(2, 1'b1, "R8 edge wins over clear");

    irq[1] = 1'b1;
    tick(3);
    check_bit(1, 1'b0, "R2 high input");
    lvl[1] = 1'b0;
    pol[1] = 1'b1;
    tick(4);
    check_bit(1, 1'b0, "R6 no edge after mode switch");
    check_vec("R6 full vector");

    for (int c = 0; c < 2000; c++) begin
      check_vec("R1 R2 R3 R4 R5 R8 random");
      if (($urandom % 64) == 0) begin
        lvl = {$urandom, $urandom};
        pol = {$urandom, $urandom};
        any = {$urandom, $urandom};
      end
      irq = irq ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      clr = {$urandom, $urandom} & {$urandom, $urandom};
      tick(1);
    end
    check_vec("R5 final");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R9 actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule